// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block produces the clock enables and the qualified reset for a small 8-bit controller core. It takes the raw oscillator clock and derives an internal tick at half that rate. The processor and the peripherals each receive that tick as a clock enable. Software stops the core with a two-bit power-control register. The idle bit stops only the processor enable, so timers, the serial port and the interrupt logic keep running. The power-down bit also drops the oscillator enable and freezes every downstream enable.

The two states are left in different ways. Any interrupt request whose enable is set ends idle: hardware clears the idle bit and emits a one-cycle wake pulse. Interrupts cannot end power-down; only a qualified reset does. The reset pin is active high and passes through a synchronizer and a run-length counter. It is accepted only after it has been sampled high on 24 consecutive oscillator edges, which is two machine cycles of 12 oscillator periods. The qualified reset clears both mode bits.

Gating is modelled with enables, not with gated clock cells. The reset qualifier samples the raw clock input, which the environment keeps toggling so that a wake-up reset can be recognised.

Top module: `pwr_ctl_top`

## Requirements
- R1: While `por_n` is low, every register is cleared. On the first edge after `por_n` is released, `sys_rst_o` is 0, `osc_en_o` is 1, `wake_o` is 0, and `per_ce_o` and `cpu_ce_o` are both 1.
- R2: While the oscillator runs, `per_ce_o` is high on every second raw clock cycle and low on the others (the input clock is divided by two).
- R3: A write with `wr_data` bit 0 set and bit 1 clear, accepted while the core runs, sets idle. From the next cycle `cpu_ce_o` stays low while `per_ce_o` keeps alternating and `osc_en_o` stays 1.
- R4: In idle, an interrupt request whose matching `irq_en` bit is set clears the idle bit and raises `wake_o` for exactly one cycle, and `cpu_ce_o` then resumes. A request whose enable bit is clear has no effect.
- R5: A write with `wr_data` bit 1 set, accepted while the core runs, enters power-down. From the next cycle `osc_en_o`, `per_ce_o` and `cpu_ce_o` are all 0.
- R6: In power-down, interrupt requests have no effect: `wake_o` stays 0 and `osc_en_o` stays 0.
- R7: `sys_rst_o` rises after the reset pin has been sampled high on 24 consecutive oscillator edges, counted after a 2-stage synchronizer, which puts the rise on the 26th edge after the pin goes high. A pulse of 23 samples leaves `sys_rst_o` and the power state unchanged.
- R8: A qualified reset clears both mode bits. `osc_en_o` is 1 on the edge after `sys_rst_o` rises, `cpu_ce_o` is 0 while `sys_rst_o` is high, and register writes made during reset are ignored.
- R9: A write with both bits set enters power-down and does not set idle.
- R10: `sys_rst_o` falls on the third edge after the reset pin goes low.
- R11: Writes are accepted only while neither mode bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, unfiltered |
| wr_en | input | 1 | Power-control register write strobe |
| wr_data | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq_req | input | IRQ_N | Interrupt request lines |
| irq_en | input | IRQ_N | Per-line interrupt enables |
| cpu_ce_o | output | 1 | Processor clock enable |
| per_ce_o | output | 1 | Peripheral and interrupt-logic clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| sys_rst_o | output | 1 | Qualified reset |
| wake_o | output | 1 | One-cycle pulse when idle ends by interrupt |

## Verification
On every cycle, the assertions check four relations. The peripheral enable never stays high for two cycles in a row. The processor enable is never high during reset. An accepted idle or power-down write stops the matching enables on the next edge. A wake pulse never lasts two cycles and never occurs while the oscillator is off. Only the bench scenarios can show the exact 24-sample reset threshold and the release latency. They also show that masked interrupts leave idle in place and that power-down ignores interrupts. Finally, they show that writes made during reset or with both bits set leave the core in the intended state, which is visible only from the enables several cycles later.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int PC_IDLE = 0;
    localparam int PC_PD   = 1;

    typedef struct packed {
        logic idle;
        logic pd;
        logic wake;
    } mode_t;
endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLES     = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin,
    output logic rst_o
);
    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] FULL = CW'(SAMPLES);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   rst;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = (st_q.sync << 1) | SYNC_STAGES'(pin);
        if (st_q.sync[SYNC_STAGES-1]) begin
            st_d.cnt = (st_q.cnt == FULL) ? st_q.cnt : st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        st_d.rst = (st_d.cnt == FULL);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_o = st_q.rst;
endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_q,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       irq_hit,
    output mode_t      mode_o
);
    mode_t mode_d, mode_q;

    always_comb begin
        mode_d      = mode_q;
        mode_d.wake = 1'b0;
        if (rst_q) begin
            mode_d.idle = 1'b0;
            mode_d.pd   = 1'b0;
        end else if (mode_q.idle) begin
            if (irq_hit) begin
                mode_d.idle = 1'b0;
                mode_d.wake = 1'b1;
            end
        end else if (!mode_q.pd && wr_en) begin
            mode_d.pd   = wr_data[PC_PD];
            mode_d.idle = wr_data[PC_IDLE] & ~wr_data[PC_PD];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/pwr_ctl_top.sv
module pwr_ctl_top
    import pwr_pkg::*;
#(
    parameter int IRQ_N       = 8,
    parameter int OSC_PER_MC  = 12,
    parameter int RST_MC      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DIV         = 2
) (
    input  logic             clk_osc,
    input  logic             por_n,
    input  logic             rst_pin,
    input  logic             wr_en,
    input  logic [1:0]       wr_data,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_en,
    output logic             cpu_ce_o,
    output logic             per_ce_o,
    output logic             osc_en_o,
    output logic             sys_rst_o,
    output logic             wake_o
);
    localparam int RST_SAMPLES = OSC_PER_MC * RST_MC;

    logic  rst_q;
    logic  tick;
    logic  irq_hit;
    mode_t mode;

    assign irq_hit = |(irq_req & irq_en);

    pwr_rst_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .SAMPLES    (RST_SAMPLES)
    ) u_rst (
        .clk  (clk_osc),
        .por_n(por_n),
        .pin  (rst_pin),
        .rst_o(rst_q)
    );

    pwr_clk_div #(.DIV(DIV)) u_div (
        .clk   (clk_osc),
        .por_n (por_n),
        .run   (~mode.pd),
        .tick_o(tick)
    );

    pwr_mode_reg u_mode (
        .clk    (clk_osc),
        .por_n  (por_n),
        .rst_q  (rst_q),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .irq_hit(irq_hit),
        .mode_o (mode)
    );

    assign cpu_ce_o  = tick & ~mode.idle & ~mode.pd & ~rst_q;
    assign per_ce_o  = tick & ~mode.pd;
    assign osc_en_o  = ~mode.pd;
    assign sys_rst_o = rst_q;
    assign wake_o    = mode.wake;
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk (
    input logic       clk_osc,
    input logic       por_n,
    input logic       wr_en,
    input logic [1:0] wr_data,
    input logic       cpu_ce_o,
    input logic       per_ce_o,
    input logic       osc_en_o,
    input logic       sys_rst_o,
    input logic       wake_o
);
    // R2
    per_alt_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        per_ce_o |=> !per_ce_o);

    // R3
    idle_stop_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        (wr_en && wr_data == 2'b01 && cpu_ce_o) |=> !cpu_ce_o);

    // R5
    pd_stop_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        (wr_en && wr_data[1] && cpu_ce_o) |=> (!osc_en_o && !per_ce_o && !cpu_ce_o));

    // R8
    rst_hold_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        sys_rst_o |-> !cpu_ce_o);

    // R8
    rst_clear_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        $rose(sys_rst_o) |=> osc_en_o);

    // R4
    wake_pulse_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        wake_o |=> !wake_o);

    // R6
    pd_no_wake_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        !osc_en_o |-> !wake_o);
endmodule

bind pwr_ctl_top pwr_ctl_chk u_chk (
    .clk_osc  (clk_osc),
    .por_n    (por_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cpu_ce_o (cpu_ce_o),
    .per_ce_o (per_ce_o),
    .osc_en_o (osc_en_o),
    .sys_rst_o(sys_rst_o),
    .wake_o   (wake_o)
);

// File: tb/sim_pwr_ctl_top.sv
`timescale 1ns/1ps
module sim_pwr_ctl_top;
    localparam int CLK_P = 10;
    localparam int IRQ_N = 8;
    localparam int SYNC  = 2;
    localparam int RST_N = 24;

    // observation bit order: {wake, sys_rst, osc_en, per_ce, cpu_ce}
    localparam logic [4:0] M_CPU  = 5'b00001;
    localparam logic [4:0] M_PER  = 5'b00010;
    localparam logic [4:0] M_OSC  = 5'b00100;
    localparam logic [4:0] M_RST  = 5'b01000;
    localparam logic [4:0] M_WAKE = 5'b10000;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             rst_pin = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_data = '0;
    logic [IRQ_N-1:0] irq_req = '0;
    logic [IRQ_N-1:0] irq_en = '0;
    logic cpu_ce, per_ce, osc_en, sys_rst, wake;

    pwr_ctl_top #(.IRQ_N(IRQ_N)) u0 (
        .clk_osc  (clk),
        .por_n    (por_n),
        .rst_pin  (rst_pin),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .cpu_ce_o (cpu_ce),
        .per_ce_o (per_ce),
        .osc_en_o (osc_en),
        .sys_rst_o(sys_rst),
        .wake_o   (wake)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        string      tag;
        logic [4:0] exp;
        logic [4:0] mask;
    } item_t;

    item_t sb[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    wire [4:0] obs = {wake, sys_rst, osc_en, per_ce, cpu_ce};

    // monitor: one expected item per edge, sampled a quarter period after it
    always @(posedge clk) begin
        item_t it;
        #(CLK_P/4);
        if (sb.size() > 0) begin
            it = sb.pop_front();
            n_run++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: got %b exp %b (mask %b)", it.tag, obs & it.mask,
                         it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic push(input string tag, input logic [4:0] e, input logic [4:0] m);
        sb.push_back('{tag, e, m});
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align();
        @(negedge clk);
        while (per_ce !== 1'b1) @(negedge clk);
    endtask

    task automatic tick_pair(input string tag, input logic cpu_on);
        push(tag, 5'b00100, M_CPU | M_PER | M_OSC);
        nclk(1);
        push(tag, {3'b001, 1'b1, cpu_on}, M_CPU | M_PER | M_OSC);
        nclk(1);
    endtask

    task automatic full_reset(input string tag);
        rst_pin = 1'b1;
        for (int k = 1; k <= SYNC + RST_N + 1; k++) begin
            if (k == SYNC + RST_N - 1) push({tag, " R7 below threshold"}, 5'b00000, M_RST);
            if (k == SYNC + RST_N)     push({tag, " R7 accepted"}, 5'b01000, M_RST | M_CPU);
            if (k == SYNC + RST_N + 1) push({tag, " R8 modes cleared"}, 5'b01100, M_RST | M_OSC | M_CPU);
            nclk(1);
        end
    endtask

    task automatic release_reset(input string tag);
        rst_pin = 1'b0;
        for (int k = 1; k <= SYNC + 1; k++) begin
            if (k == SYNC)     push({tag, " R10 still held"}, 5'b01000, M_RST);
            if (k == SYNC + 1) push({tag, " R10 released"}, 5'b00000, M_RST);
            nclk(1);
        end
    endtask

    initial begin
        nclk(3);
        por_n = 1'b1;
        push("R1 reset state", 5'b00111, 5'b11111);
        nclk(1);
        push("R2 low phase", 5'b00000, M_CPU | M_PER);
        nclk(1);
        align();
        tick_pair("R2 running", 1'b1);

        // idle entry
        align();
        wr_en = 1'b1; wr_data = 2'b01;
        push("R3 idle entry", 5'b00100, M_CPU | M_PER | M_OSC);
        nclk(1);
        wr_en = 1'b0;
        push("R3 peripherals run", 5'b00110, M_CPU | M_PER | M_OSC);
        nclk(1);
        tick_pair("R3 cpu held", 1'b0);

        // masked interrupt
        irq_req = 8'h10; irq_en = 8'h0F;
        repeat (4) begin
            push("R4 masked irq", 5'b00000, M_WAKE);
            nclk(1);
        end
        align();
        tick_pair("R4 masked keeps idle", 1'b0);

        // enabled interrupt wakes
        irq_en = 8'h10;
        push("R4 wake pulse", 5'b10000, M_WAKE);
        nclk(1);
        irq_req = '0;
        push("R4 wake one cycle", 5'b00000, M_WAKE);
        nclk(1);
        align();
        tick_pair("R4 cpu resumes", 1'b1);

        // power-down
        align();
        wr_en = 1'b1; wr_data = 2'b10;
        push("R5 pd entry", 5'b00000, M_CPU | M_PER | M_OSC);
        nclk(1);
        wr_en = 1'b0;
        repeat (3) begin
            push("R5 pd holds", 5'b00000, M_CPU | M_PER | M_OSC | M_RST);
            nclk(1);
        end

        // interrupts ignored in power-down
        irq_req = 8'h01; irq_en = 8'h01;
        repeat (4) begin
            push("R6 irq ignored", 5'b00000, M_WAKE | M_OSC);
            nclk(1);
        end
        irq_req = '0;

        // short reset pulse
        rst_pin = 1'b1;
        for (int k = 1; k <= RST_N - 1; k++) begin
            push("R7 short pulse", 5'b00000, M_RST | M_OSC);
            nclk(1);
        end
        rst_pin = 1'b0;
        repeat (SYNC + 3) begin
            push("R7 short pulse ignored", 5'b00000, M_RST | M_OSC);
            nclk(1);
        end

        // full reset leaves power-down; writes during reset ignored
        full_reset("pd exit");
        wr_en = 1'b1; wr_data = 2'b11;
        push("R8 write in reset", 5'b01100, M_RST | M_OSC | M_CPU);
        nclk(1);
        wr_en = 1'b0;
        release_reset("pd exit");
        align();
        tick_pair("R8 write in reset ignored", 1'b1);

        // writes ignored while idle
        align();
        wr_en = 1'b1; wr_data = 2'b01;
        nclk(1);
        wr_data = 2'b10;
        push("R11 write in idle", 5'b00100, M_OSC);
        nclk(1);
        wr_en = 1'b0;
        push("R11 idle write ignored", 5'b00100, M_OSC);
        nclk(1);
        irq_req = 8'h01; irq_en = 8'h01;
        push("R11 wake from idle", 5'b10000, M_WAKE);
        nclk(1);
        irq_req = '0;
        align();
        tick_pair("R11 back to run", 1'b1);

        // both bits written
        align();
        wr_en = 1'b1; wr_data = 2'b11;
        push("R9 both bits pd", 5'b00000, M_CPU | M_PER | M_OSC);
        nclk(1);
        wr_en = 1'b0;
        push("R9 pd priority", 5'b00000, M_PER | M_OSC);
        nclk(1);
        full_reset("second");
        release_reset("second");
        align();
        tick_pair("R9 no idle after reset", 1'b1);

        nclk(3);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule